// File: doc/BRIEF.md
# Sleep and Wake Controller

This block is the power-management sequencer of a small microcontroller core. Software chooses one of four sleep depths with a 2-bit mode field and sets a sleep-enable bit. A one-cycle pulse from the sleep instruction then parks the core. While the core sleeps, the block gates the CPU clock and may drop the main oscillator enable. It also drives a separate enable for each peripheral domain, so that only the domains the chosen depth keeps alive stay clocked.

Each depth has its own set of events that can end the sleep. After an interrupt wake the core is held for a fixed halt period and is then told to service the interrupt. After that it resumes after the sleep instruction. A reset request while asleep cuts the sequence short and signals a restart from the reset vector. In the two deepest modes, an external level interrupt counts only after it has been seen active on consecutive strobes of the slow watchdog-domain sample clock.

Top module: `slpwk_ctrl`

## Requirements
- R1: A sleep instruction pulse (`sleep_req`) puts the block to sleep only when `sleep_en` is 1 in the same cycle. With `sleep_en` at 0 the pulse is ignored: `cpu_clk_en` stays 1 and `in_sleep` stays 0.
- R2: `sleep_mode` selects the depth: 0 = idle, 1 = ADC quiet, 2 = power-down, 3 = power-save. The value is captured when sleep is entered. `dom_en` bit positions are: 0 SPI, 1 UART, 2 comparator, 3 ADC, 4 two-wire, 5 timers 0/1, 6 timer 2, 7 watchdog, 8 external interrupts. Outside sleep, all bits of `dom_en` are 1.
- R3: Idle stops only the CPU clock, so `dom_en` = 0x1FF and `osc_en` = 1. In idle, `irq_pending` wakes the core.
- R4: ADC quiet keeps `dom_en` = 0x1D8. It wakes on `adc_done`, `ext_level`, `twi_match` or `t2_event`. `irq_pending` alone does not wake it.
- R5: In ADC quiet, a `t2_event` wake requests service only when `t2_async` is 1. Otherwise the core resumes with no `irq_service` pulse.
- R6: On entry to idle or ADC quiet with `adc_on` = 1, `adc_start` is high for exactly the one cycle after entry. On entry to the other modes, or with `adc_on` = 0, `adc_start` stays 0.
- R7: Power-down sets `dom_en` = 0x190 and `osc_en` = 0. Only `twi_match`, a qualified level wake or `rst_wake` end it. `adc_done`, `t2_event` and `irq_pending` are ignored.
- R8: In power-down and power-save, `ext_level` wakes the core only after it is 1 on FILT_SAMPLES (default 2) consecutive `wdt_tick` strobes. A strobe that sees it at 0 restarts the count.
- R9: After an interrupt wake, `cpu_clk_en` stays 0 for HALT_CYCLES (default 4) cycles of halt. `irq_service` is then pulsed for one cycle, in the same cycle that `cpu_clk_en` returns to 1.
- R10: `rst_wake` while asleep, during oscillator restore or during the halt returns the core at the next edge. `restart` pulses for one cycle and `irq_service` is not raised.
- R11: Waking from power-down or power-save first raises `osc_en` for OSC_WAIT_CYCLES (default 1) cycles with the CPU clock still off. Only then does the halt count start, so `cpu_clk_en` returns 6 cycles after the wake edge instead of 5.
- R12: Power-save keeps the power-down wake set and additionally keeps timer 2 on (`dom_en` = 0x1D0). In power-save, `t2_event` wakes the core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Active-low controller reset |
| sleep_en | input | 1 | Sleep permitted |
| sleep_mode | input | 2 | Requested depth |
| sleep_req | input | 1 | One-cycle sleep instruction pulse |
| adc_on | input | 1 | ADC is enabled |
| irq_pending | input | 1 | Any enabled interrupt is pending |
| adc_done | input | 1 | ADC conversion complete |
| ext_level | input | 1 | External interrupt line at its active level |
| twi_match | input | 1 | Two-wire address match |
| t2_event | input | 1 | Timer 2 compare or overflow |
| t2_async | input | 1 | Timer 2 runs from its own clock |
| wdt_tick | input | 1 | Watchdog-domain sample strobe |
| rst_wake | input | 1 | External, watchdog or brown-out reset request |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| osc_en | output | 1 | Main oscillator enable |
| dom_en | output | 9 | Peripheral domain enables |
| adc_start | output | 1 | Conversion start pulse |
| irq_service | output | 1 | Service the wake interrupt |
| restart | output | 1 | Restart from the reset vector |
| in_sleep | output | 1 | Core is in a sleep state |

## Verification
The bench builds the block with its defaults: HALT_CYCLES = 4, OSC_WAIT_CYCLES = 1 and FILT_SAMPLES = 2. With these values the wake-to-run distance is 5 cycles for shallow modes and 6 for deep ones, and both can be counted exactly. A two-strobe filter lets a single interrupted level sequence show both rejection and qualification. A nonzero oscillator wait reaches the restore state, so the cycle in which the oscillator runs but the CPU clock is still gated can be observed.

// File: rtl/slpwk_pkg.sv
package slpwk_pkg;

   typedef enum logic [1:0] {
      MODE_IDLE  = 2'd0,
      MODE_ADCQ  = 2'd1,
      MODE_PDOWN = 2'd2,
      MODE_PSAVE = 2'd3
   } slp_mode_e;

   typedef enum logic [1:0] {
      ST_RUN,
      ST_SLEEP,
      ST_OSC,
      ST_HALT
   } slp_state_e;

   localparam int DOM_W   = 9;
   localparam int D_SPI   = 0;
   localparam int D_UART  = 1;
   localparam int D_ACMP  = 2;
   localparam int D_ADC   = 3;
   localparam int D_TWI   = 4;
   localparam int D_TMR01 = 5;
   localparam int D_TMR2  = 6;
   localparam int D_WDT   = 7;
   localparam int D_EXT   = 8;

   function automatic logic [DOM_W-1:0] keep_mask(slp_mode_e m);
      logic [DOM_W-1:0] k;
      k = '0;
      unique case (m)
         MODE_IDLE: k = '1;
         MODE_ADCQ: begin
            k[D_ADC] = 1'b1; k[D_TWI] = 1'b1; k[D_TMR2] = 1'b1;
            k[D_WDT] = 1'b1; k[D_EXT] = 1'b1;
         end
         MODE_PDOWN: begin
            k[D_TWI] = 1'b1; k[D_WDT] = 1'b1; k[D_EXT] = 1'b1;
         end
         MODE_PSAVE: begin
            k[D_TWI] = 1'b1; k[D_WDT] = 1'b1; k[D_EXT] = 1'b1;
            k[D_TMR2] = 1'b1;
         end
      endcase
      return k;
   endfunction

endpackage

// File: rtl/slpwk_level_filter.sv
module slpwk_level_filter #(
   parameter int SAMPLES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic tick,
   input  logic level,
   output logic qual
);
   localparam int CW = $clog2(SAMPLES + 1);

   generate
      if (SAMPLES < 1) begin : g_bad_samples
         $error("SAMPLES must be at least 1");
      end
   endgenerate

   logic [CW-1:0] run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_cnt <= '0;
      end else if (!arm) begin
         run_cnt <= '0;
      end else if (tick) begin
         if (!level)                           run_cnt <= '0;
         else if (run_cnt != CW'(SAMPLES))     run_cnt <= run_cnt + 1'b1;
      end
   end

   assign qual = arm && (run_cnt == CW'(SAMPLES));

   // R8: qualification appears only right after a strobe that saw the level
   p_qual_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(run_cnt == CW'(SAMPLES)) |-> $past(tick && level)));
   // R8: a strobe seeing the inactive level drops qualification
   p_drop_on_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (arm && tick && !level) |=> !qual);

endmodule

// File: rtl/slpwk_span_timer.sv
module slpwk_span_timer #(
   parameter int SPAN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic last
);
   localparam int CW = $clog2(SPAN + 1);

   generate
      if (SPAN < 1) begin : g_bad_span
         $error("SPAN must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (!run) cnt <= '0;
      else if (!last) cnt <= cnt + 1'b1;
   end

   assign last = run && (cnt == CW'(SPAN - 1));

endmodule

// File: rtl/slpwk_mode_decode.sv
module slpwk_mode_decode
   import slpwk_pkg::*;
(
   input  slp_mode_e        mode,
   input  logic             irq_pending,
   input  logic             adc_done,
   input  logic             ext_level,
   input  logic             lvl_qual,
   input  logic             twi_match,
   input  logic             t2_event,
   input  logic             t2_async,
   output logic [DOM_W-1:0] dom_keep,
   output logic             osc_off,
   output logic             wake_int,
   output logic             svc_req
);
   logic other;
   logic t2_irq;

   assign t2_irq = t2_event && t2_async;

   always_comb begin
      other    = 1'b0;
      wake_int = 1'b0;
      svc_req  = 1'b0;
      unique case (mode)
         MODE_IDLE: begin
            other    = irq_pending;
            wake_int = other;
            svc_req  = other;
         end
         MODE_ADCQ: begin
            other    = adc_done || ext_level || twi_match;
            wake_int = other || t2_event;
            svc_req  = other || t2_irq;
         end
         MODE_PDOWN: begin
            other    = twi_match || lvl_qual;
            wake_int = other;
            svc_req  = other;
         end
         MODE_PSAVE: begin
            other    = twi_match || lvl_qual;
            wake_int = other || t2_event;
            svc_req  = other || t2_irq;
         end
      endcase
   end

   assign dom_keep = keep_mask(mode);
   assign osc_off  = (mode == MODE_PDOWN) || (mode == MODE_PSAVE);

endmodule

// File: rtl/slpwk_ctrl.sv
module slpwk_ctrl
   import slpwk_pkg::*;
#(
   parameter int HALT_CYCLES     = 4,
   parameter int OSC_WAIT_CYCLES = 1,
   parameter int FILT_SAMPLES    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sleep_en,
   input  logic [1:0]       sleep_mode,
   input  logic             sleep_req,
   input  logic             adc_on,
   input  logic             irq_pending,
   input  logic             adc_done,
   input  logic             ext_level,
   input  logic             twi_match,
   input  logic             t2_event,
   input  logic             t2_async,
   input  logic             wdt_tick,
   input  logic             rst_wake,
   output logic             cpu_clk_en,
   output logic             osc_en,
   output logic [DOM_W-1:0] dom_en,
   output logic             adc_start,
   output logic             irq_service,
   output logic             restart,
   output logic             in_sleep
);
   localparam bit USE_OSC_WAIT = (OSC_WAIT_CYCLES > 0);

   generate
      if (HALT_CYCLES < 1) begin : g_bad_halt
         $error("HALT_CYCLES must be at least 1");
      end
      if (OSC_WAIT_CYCLES < 0) begin : g_bad_osc
         $error("OSC_WAIT_CYCLES must not be negative");
      end
   endgenerate

   slp_state_e       st;
   slp_mode_e        mode_q;
   slp_mode_e        req_mode;
   logic             svc_q;
   logic             lvl_qual;
   logic             halt_done;
   logic             osc_done;
   logic [DOM_W-1:0] dom_keep;
   logic             osc_off;
   logic             wake_int;
   logic             svc_req;
   logic             enter;

   assign req_mode = slp_mode_e'(sleep_mode);
   assign enter    = (st == ST_RUN) && sleep_req && sleep_en;

   slpwk_mode_decode u_dec (
      .mode        (mode_q),
      .irq_pending (irq_pending),
      .adc_done    (adc_done),
      .ext_level   (ext_level),
      .lvl_qual    (lvl_qual),
      .twi_match   (twi_match),
      .t2_event    (t2_event),
      .t2_async    (t2_async),
      .dom_keep    (dom_keep),
      .osc_off     (osc_off),
      .wake_int    (wake_int),
      .svc_req     (svc_req)
   );

   slpwk_level_filter #(.SAMPLES(FILT_SAMPLES)) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .arm   ((st == ST_SLEEP) && osc_off),
      .tick  (wdt_tick),
      .level (ext_level),
      .qual  (lvl_qual)
   );

   slpwk_span_timer #(.SPAN(HALT_CYCLES)) u_halt (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (st == ST_HALT),
      .last  (halt_done)
   );

   generate
      if (USE_OSC_WAIT) begin : g_osc_wait
         slpwk_span_timer #(.SPAN(OSC_WAIT_CYCLES)) u_osc (
            .clk   (clk),
            .rst_n (rst_n),
            .run   (st == ST_OSC),
            .last  (osc_done)
         );
      end else begin : g_no_osc_wait
         assign osc_done = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= ST_RUN;
         mode_q      <= MODE_IDLE;
         svc_q       <= 1'b0;
         adc_start   <= 1'b0;
         irq_service <= 1'b0;
         restart     <= 1'b0;
      end else begin
         adc_start   <= 1'b0;
         irq_service <= 1'b0;
         restart     <= 1'b0;
         unique case (st)
            ST_RUN: begin
               if (enter) begin
                  st        <= ST_SLEEP;
                  mode_q    <= req_mode;
                  adc_start <= adc_on &&
                               (req_mode == MODE_IDLE || req_mode == MODE_ADCQ);
               end
            end
            ST_SLEEP: begin
               if (rst_wake) begin
                  st      <= ST_RUN;
                  restart <= 1'b1;
               end else if (wake_int) begin
                  svc_q <= svc_req;
                  st    <= (osc_off && USE_OSC_WAIT) ? ST_OSC : ST_HALT;
               end
            end
            ST_OSC: begin
               if (rst_wake) begin
                  st      <= ST_RUN;
                  restart <= 1'b1;
               end else if (osc_done) begin
                  st <= ST_HALT;
               end
            end
            ST_HALT: begin
               if (rst_wake) begin
                  st      <= ST_RUN;
                  restart <= 1'b1;
               end else if (halt_done) begin
                  st          <= ST_RUN;
                  irq_service <= svc_q;
               end
            end
         endcase
      end
   end

   assign cpu_clk_en = (st == ST_RUN);
   assign in_sleep   = (st == ST_SLEEP);
   assign osc_en     = !((st == ST_SLEEP) && osc_off);
   assign dom_en     = (st == ST_SLEEP) ? dom_keep : {DOM_W{1'b1}};

   // R1: a pulse without the enable leaves the core running
   p_ignore_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == ST_RUN) && sleep_req && !sleep_en) |=> cpu_clk_en);
   // R6: the conversion start is a single pulse issued just after entry
   p_adc_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      adc_start |-> (in_sleep && $past(st == ST_RUN) && !$past(adc_start)));
   // R7: the oscillator is off only while sleeping in a deep mode
   p_osc_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !osc_en |-> (in_sleep && !cpu_clk_en &&
                   (mode_q == MODE_PDOWN || mode_q == MODE_PSAVE)));
   // R9: service follows the halt and coincides with the clock returning
   p_svc_after_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_service |-> ($past(st == ST_HALT) && cpu_clk_en));
   // R10: a reset request ends any non-running state at the next edge
   p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((st != ST_RUN) && rst_wake) |=> (restart && cpu_clk_en && !irq_service));
   // R11: a deep-mode wake restores the oscillator before the CPU clock
   p_osc_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (in_sleep && osc_off && wake_int && !rst_wake) |=> (osc_en && !cpu_clk_en));

endmodule

// File: tb/slpwk_ctrl_test.sv
module slpwk_ctrl_test;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sleep_en = 1'b0, sleep_req = 1'b0, adc_on = 1'b0;
   logic [1:0] sleep_mode = 2'd0;
   logic       irq_pending = 1'b0, adc_done = 1'b0, ext_level = 1'b0;
   logic       twi_match = 1'b0, t2_event = 1'b0, t2_async = 1'b0;
   logic       wdt_tick = 1'b0, rst_wake = 1'b0;
   logic       cpu_clk_en, osc_en, adc_start, irq_service, restart, in_sleep;
   logic [8:0] dom_en;

   int n_run = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   slpwk_ctrl uut (
      .clk(clk), .rst_n(rst_n), .sleep_en(sleep_en), .sleep_mode(sleep_mode),
      .sleep_req(sleep_req), .adc_on(adc_on), .irq_pending(irq_pending),
      .adc_done(adc_done), .ext_level(ext_level), .twi_match(twi_match),
      .t2_event(t2_event), .t2_async(t2_async), .wdt_tick(wdt_tick),
      .rst_wake(rst_wake), .cpu_clk_en(cpu_clk_en), .osc_en(osc_en),
      .dom_en(dom_en), .adc_start(adc_start), .irq_service(irq_service),
      .restart(restart), .in_sleep(in_sleep)
   );

   // source bits: 0 irq, 1 adc_done, 2 level(+strobes), 3 twi, 4 t2, 5 reset
   typedef struct packed {
      logic [1:0] mode;
      logic       adc;
      logic       t2a;
      logic [5:0] src;
      logic       e_adcs;
      logic [8:0] e_dom;
      logic       e_osc;
      logic       e_wake;
      logic       e_svc;
      logic       e_rst;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VECS [NV] = '{
      '{2'd0, 1'b1, 1'b0, 6'h01, 1'b1, 9'h1FF, 1'b1, 1'b1, 1'b1, 1'b0},
      '{2'd0, 1'b0, 1'b0, 6'h20, 1'b0, 9'h1FF, 1'b1, 1'b1, 1'b0, 1'b1},
      '{2'd1, 1'b1, 1'b0, 6'h02, 1'b1, 9'h1D8, 1'b1, 1'b1, 1'b1, 1'b0},
      '{2'd1, 1'b0, 1'b0, 6'h01, 1'b0, 9'h1D8, 1'b1, 1'b0, 1'b0, 1'b0},
      '{2'd1, 1'b0, 1'b0, 6'h10, 1'b0, 9'h1D8, 1'b1, 1'b1, 1'b0, 1'b0},
      '{2'd1, 1'b0, 1'b1, 6'h10, 1'b0, 9'h1D8, 1'b1, 1'b1, 1'b1, 1'b0},
      '{2'd1, 1'b0, 1'b0, 6'h04, 1'b0, 9'h1D8, 1'b1, 1'b1, 1'b1, 1'b0},
      '{2'd1, 1'b0, 1'b0, 6'h08, 1'b0, 9'h1D8, 1'b1, 1'b1, 1'b1, 1'b0},
      '{2'd2, 1'b1, 1'b0, 6'h02, 1'b0, 9'h190, 1'b0, 1'b0, 1'b0, 1'b0},
      '{2'd2, 1'b0, 1'b1, 6'h10, 1'b0, 9'h190, 1'b0, 1'b0, 1'b0, 1'b0},
      '{2'd2, 1'b0, 1'b0, 6'h08, 1'b0, 9'h190, 1'b0, 1'b1, 1'b1, 1'b0},
      '{2'd2, 1'b0, 1'b0, 6'h04, 1'b0, 9'h190, 1'b0, 1'b1, 1'b1, 1'b0},
      '{2'd3, 1'b0, 1'b1, 6'h10, 1'b0, 9'h1D0, 1'b0, 1'b1, 1'b1, 1'b0},
      '{2'd3, 1'b0, 1'b0, 6'h01, 1'b0, 9'h1D0, 1'b0, 1'b0, 1'b0, 1'b0},
      '{2'd2, 1'b0, 1'b0, 6'h20, 1'b0, 9'h190, 1'b0, 1'b1, 1'b0, 1'b1},
      '{2'd3, 1'b0, 1'b0, 6'h04, 1'b0, 9'h1D0, 1'b0, 1'b1, 1'b1, 1'b0}
   };

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic enter(input logic [1:0] m, input logic adc);
      @(negedge clk);
      sleep_mode = m; adc_on = adc; sleep_en = 1'b1; sleep_req = 1'b1;
      @(negedge clk);
      sleep_req = 1'b0; sleep_en = 1'b0;
   endtask

   task automatic strobe(input logic lvl);
      @(negedge clk);
      wdt_tick = 1'b1; ext_level = lvl;
      @(negedge clk);
      wdt_tick = 1'b0; ext_level = 1'b0;
   endtask

   task automatic clear_src();
      irq_pending = 0; adc_done = 0; ext_level = 0; wdt_tick = 0;
      twi_match = 0; t2_event = 0; rst_wake = 0;
   endtask

   // counts negedges from the current one until cpu_clk_en is seen high
   task automatic wait_run(output int n, output bit svc, output bit rs);
      n = 0; svc = 0; rs = 0;
      for (int k = 0; k < 14; k++) begin
         if (irq_service) svc = 1;
         if (restart) rs = 1;
         if (cpu_clk_en) break;
         @(negedge clk);
         n++;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      int  n;
      bit  svc, rs;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state, R2
      chk(cpu_clk_en && osc_en && !in_sleep && !adc_start && !irq_service && !restart,
          "R2 reset outputs", {cpu_clk_en, osc_en, in_sleep}, 3'b110);
      chk(dom_en == 9'h1FF, "R2 reset domains", dom_en, 9'h1FF);

      // R1: pulse ignored without enable
      @(negedge clk);
      sleep_mode = 2'd2; sleep_req = 1'b1; sleep_en = 1'b0; adc_on = 1'b1;
      @(negedge clk);
      sleep_req = 1'b0;
      chk(cpu_clk_en && !in_sleep && osc_en && !adc_start, "R1 ignored pulse",
          {cpu_clk_en, in_sleep}, 2'b10);

      // table walk: R2 R3 R4 R5 R6 R7 R8 R10 R12
      for (int i = 0; i < NV; i++) begin
         vec_t v;
         bit woke;
         v = VECS[i];
         t2_async = v.t2a;
         enter(v.mode, v.adc);
         chk(adc_start == v.e_adcs, $sformatf("R6 v%0d adc_start", i), adc_start, v.e_adcs);
         chk(dom_en == v.e_dom, $sformatf("R2 v%0d dom_en", i), dom_en, v.e_dom);
         chk(osc_en == v.e_osc, $sformatf("R7 v%0d osc_en", i), osc_en, v.e_osc);
         chk(!cpu_clk_en && in_sleep, $sformatf("R3 v%0d asleep", i), cpu_clk_en, 0);
         irq_pending = v.src[0]; adc_done = v.src[1];
         ext_level = v.src[2]; wdt_tick = v.src[2];
         twi_match = v.src[3]; t2_event = v.src[4]; rst_wake = v.src[5];
         @(negedge clk);
         if (v.src[2]) @(negedge clk);
         clear_src();
         wait_run(n, svc, rs);
         woke = cpu_clk_en;
         chk(woke == v.e_wake, $sformatf("R4 v%0d wake", i), woke, v.e_wake);
         chk(svc == v.e_svc, $sformatf("R5 v%0d service", i), svc, v.e_svc);
         chk(rs == v.e_rst, $sformatf("R10 v%0d restart", i), rs, v.e_rst);
         if (!woke) begin
            rst_wake = 1'b1;
            @(negedge clk);
            rst_wake = 1'b0;
            chk(restart && cpu_clk_en, $sformatf("R10 v%0d exit", i), restart, 1);
         end
         @(negedge clk);
      end
      t2_async = 1'b0;

      // R6 pulse width and R9 exact halt in idle
      enter(2'd0, 1'b1);
      chk(adc_start == 1'b1, "R6 pulse high", adc_start, 1);
      @(negedge clk);
      chk(adc_start == 1'b0, "R6 pulse one cycle", adc_start, 0);
      irq_pending = 1'b1;
      @(negedge clk);
      irq_pending = 1'b0;
      wait_run(n, svc, rs);
      chk(n == 4, "R9 halt cycles idle", n + 1, 5);
      chk(irq_service, "R9 service with clock", irq_service, 1);
      @(negedge clk);
      chk(!irq_service, "R9 service one cycle", irq_service, 0);

      // R11 oscillator restored first in power-down
      enter(2'd2, 1'b0);
      twi_match = 1'b1;
      @(negedge clk);
      twi_match = 1'b0;
      chk(osc_en && !cpu_clk_en && !in_sleep, "R11 osc before cpu",
          {osc_en, cpu_clk_en}, 2'b10);
      wait_run(n, svc, rs);
      chk(n == 5 && svc, "R11 deep wake latency", n + 1, 6);
      @(negedge clk);

      // R8 broken level sequence is rejected, then qualifies
      enter(2'd2, 1'b0);
      strobe(1'b1);
      strobe(1'b0);
      strobe(1'b1);
      repeat (4) @(negedge clk);
      chk(in_sleep, "R8 broken level ignored", in_sleep, 1);
      strobe(1'b1);
      wait_run(n, svc, rs);
      chk(cpu_clk_en && svc, "R8 qualified level wakes", cpu_clk_en, 1);
      @(negedge clk);

      // R10 reset during the halt cancels service
      enter(2'd0, 1'b0);
      irq_pending = 1'b1;
      @(negedge clk);
      irq_pending = 1'b0;
      @(negedge clk);
      rst_wake = 1'b1;
      @(negedge clk);
      rst_wake = 1'b0;
      chk(restart && cpu_clk_en, "R10 reset in halt", restart, 1);
      svc = 0;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         if (irq_service) svc = 1;
      end
      chk(!svc, "R10 no service after reset", svc, 0);

      // R12 power-save keeps timer 2 and wakes on it
      t2_async = 1'b1;
      enter(2'd3, 1'b0);
      chk(dom_en[6] && !osc_en, "R12 timer2 kept", dom_en, 9'h1D0);
      t2_event = 1'b1;
      @(negedge clk);
      t2_event = 1'b0;
      wait_run(n, svc, rs);
      chk(cpu_clk_en && svc && n == 5, "R12 timer2 wake", n + 1, 6);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule